// File: doc/BRIEF.md
# Wide register read latch

This block sits between a 32-bit host read port and a bank of wide storage. The bank holds 128-bit control/status registers and 64-bit SRAM words. The host cannot read a wide value in one access, so it reads it as consecutive 32-bit dwords. The block keeps one 128-bit snapshot and a tag that names the word the snapshot came from. For each host read it decides one of two things: sample the bank afresh, or serve the requested dword from the snapshot. In this way every dword of one wide value comes from the same instant.

A fresh sample is taken on any of three events:
- a read of dword 0;
- a read of a word other than the one tagged;
- the first read after reset.

Only in that cycle does the block raise a one-cycle strobe toward the bank. The bank uses the strobe to apply its clear-on-read side effects, so each snapshot causes exactly one read event. Reads of the upper dwords of the tagged word never touch the bank. The bank must present the addressed word combinationally in the request cycle.

Top module: `wide_rd_latch`

## Requirements
- R1: While `rst_n` is low at a clock edge, the edge leaves `host_rvalid` low and the snapshot is marked empty. With no read request, `snap_csr` and `snap_sram` stay low.
- R2: A read of dword 0 of a wide register captures all 128 bits of `csr_word` into the snapshot and returns bits 31:0 of that value.
- R3: A read of any dword of a word other than the one tagged captures a fresh snapshot of that word and returns the requested dword of it.
- R4: A read of dword 1, 2 or 3 of the tagged word returns that dword from the snapshot, even if the live bank value has changed since the capture. It raises no strobe.
- R5: `snap_csr` (register region) or `snap_sram` (SRAM region) is high for exactly the request cycle of a read that captures. The two strobes are never high together, and neither is high without `host_rd`.
- R6: The first read after reset captures, whatever its dword offset.
- R7: An SRAM word is 64 bits, read as dword 0 (offset 0) and dword 1 (offset 4). The same capture rules apply to it. An SRAM word and a register never share a tag.
- R8: `host_rdata` carries the result and `host_rvalid` is high in the cycle after a read request. `host_rvalid` is low after a cycle without a request.
- R9: Address decode works as follows.
  - `host_addr[ADDR_W-1]` selects the region: 0 for registers, 1 for SRAM.
  - For a register, the index is `host_addr[ADDR_W-2:4]` and the dword is `host_addr[3:2]`.
  - For SRAM, the index is `host_addr[ADDR_W-2:3]` and the dword is `host_addr[2]`.
  - `host_addr[1:0]` is ignored.
  - `csr_idx` and `sram_idx` follow the address combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_rd | input | 1 | Host read request, one per cycle |
| host_addr | input | ADDR_W | Byte address of the requested dword |
| host_rdata | output | 32 | Returned dword |
| host_rvalid | output | 1 | High in the cycle after a request |
| csr_idx | output | ADDR_W-5 | Register index presented to the bank |
| csr_word | input | 128 | Live value of the indexed register |
| sram_idx | output | ADDR_W-4 | SRAM word index presented to the bank |
| sram_word | input | 64 | Live value of the indexed SRAM word |
| snap_csr | output | 1 | Capture strobe for the register region |
| snap_sram | output | 1 | Capture strobe for the SRAM region |

## Verification
The capture strobes and the bank indices depend combinationally on the request, so they are due in the request cycle itself. The returned dword and its valid flag are due one clock edge later.

The bench drives each request 2 ns after a rising edge and judges everything at the following falling edge. At that falling edge it compares the strobes with the model's decision for the request now applied, and compares data and valid with the result predicted for the previous request. Between reads, the bench moves a drift value that feeds the live bank words. A dword wrongly served live, instead of from the snapshot, therefore shows up at once.

// File: rtl/wrl_pkg.sv
// Package: shared constants and the region encoding for the wide read latch.
// Assumes a 32-bit host data path and wide words that are whole multiples of it.
package wrl_pkg;
    localparam int DWORD_W = 32;
    localparam int WIDE_W  = 128;
    localparam int SRAM_W  = 64;

    typedef enum logic {
        REGION_CSR  = 1'b0,
        REGION_SRAM = 1'b1
    } region_e;
endpackage

// File: rtl/wrl_addr_decode.sv
// Module: wrl_addr_decode
// Splits a host byte address into region, bank indices, dword select and a
// tag key. The key is unique per wide word across both regions.
// Assumes: the top address bit selects the region, registers are 16 bytes
// apart and SRAM words 8 bytes apart. Bits [1:0] carry no meaning.
module wrl_addr_decode
    import wrl_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [ADDR_W-6:0] csr_idx,
    output logic [ADDR_W-5:0] sram_idx,
    output logic [1:0]        dw_sel,
    output logic              is_dw0,
    output logic [ADDR_W-4:0] key
);
    logic unused_low_bits;

    // Ignore the byte lane bits.
    assign unused_low_bits = ^addr[1:0];

    // Region and index fields.
    assign region   = region_e'(addr[ADDR_W-1]);
    assign csr_idx  = addr[ADDR_W-2:4];
    assign sram_idx = addr[ADDR_W-2:3];

    // Dword select and key depend on the word size of the region.
    always_comb begin
        if (region == REGION_SRAM) begin
            dw_sel = {1'b0, addr[2]};
            key    = {addr[ADDR_W-1:4], addr[3]};
        end else begin
            dw_sel = addr[3:2];
            key    = {addr[ADDR_W-1:4], 1'b0};
        end
        is_dw0 = (dw_sel == 2'd0);
    end
endmodule

// File: rtl/wrl_capture_ctl.sv
// Module: wrl_capture_ctl
// Holds the snapshot valid flag and tag. Decides per read whether a fresh
// snapshot is needed.
// Assumes: at most one read per cycle. A capture takes effect at the next edge.
module wrl_capture_ctl #(
    parameter int KEY_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  logic [KEY_W-1:0] key,
    input  logic             is_dw0,
    output logic             capture
);
    logic             valid_q;
    logic [KEY_W-1:0] tag_q;

    // Capture on an empty latch, on dword 0, or on a different word.
    assign capture = rd && (!valid_q || is_dw0 || (tag_q != key));

    // Track which word the snapshot belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else if (capture) begin
            valid_q <= 1'b1;
            tag_q   <= key;
        end
    end
endmodule

// File: rtl/wrl_snapshot.sv
// Module: wrl_snapshot
// Stores the wide snapshot and returns the selected dword one cycle after
// the request. On a capture the dword comes straight from the fresh value.
// Assumes: SRAM words fill the low part of the snapshot, upper part zeroed.
module wrl_snapshot
    import wrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd,
    input  logic               capture,
    input  region_e            region,
    input  logic [1:0]         dw_sel,
    input  logic [WIDE_W-1:0]  csr_word,
    input  logic [SRAM_W-1:0]  sram_word,
    output logic [DWORD_W-1:0] rdata,
    output logic               rvalid
);
    localparam int NDW = WIDE_W / DWORD_W;

    logic [WIDE_W-1:0]  latch_q;
    logic [WIDE_W-1:0]  fresh;
    logic [WIDE_W-1:0]  src;
    logic [DWORD_W-1:0] dw_arr [NDW];

    // Widen the region's live word to the snapshot width.
    always_comb begin
        if (region == REGION_SRAM)
            fresh = {{(WIDE_W-SRAM_W){1'b0}}, sram_word};
        else
            fresh = csr_word;
        src = capture ? fresh : latch_q;
    end

    // Slice the source into dwords.
    for (genvar g = 0; g < NDW; g++) begin : g_dw
        assign dw_arr[g] = src[g*DWORD_W +: DWORD_W];
    end

    // Load the snapshot and register the returned dword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            rdata   <= '0;
            rvalid  <= 1'b0;
        end else begin
            rvalid <= rd;
            if (capture)
                latch_q <= fresh;
            if (rd)
                rdata <= dw_arr[dw_sel];
        end
    end
endmodule

// File: rtl/wide_rd_latch.sv
// Module: wide_rd_latch (top)
// Host-side read latch for 128-bit registers and 64-bit SRAM words. Lets
// the host read a wide word dword by dword from one snapshot. Strobes the
// bank exactly once per snapshot.
// Assumes: the bank returns csr_word/sram_word combinationally for the
// presented index, and applies clear-on-read at the edge where a strobe is high.
module wide_rd_latch
    import wrl_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_rd,
    input  logic [ADDR_W-1:0]  host_addr,
    output logic [DWORD_W-1:0] host_rdata,
    output logic               host_rvalid,
    output logic [ADDR_W-6:0]  csr_idx,
    input  logic [WIDE_W-1:0]  csr_word,
    output logic [ADDR_W-5:0]  sram_idx,
    input  logic [SRAM_W-1:0]  sram_word,
    output logic               snap_csr,
    output logic               snap_sram
);
    localparam int KEY_W = ADDR_W - 3;

    region_e          region;
    logic [1:0]       dw_sel;
    logic             is_dw0;
    logic [KEY_W-1:0] key;
    logic             capture;

    wrl_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr     (host_addr),
        .region   (region),
        .csr_idx  (csr_idx),
        .sram_idx (sram_idx),
        .dw_sel   (dw_sel),
        .is_dw0   (is_dw0),
        .key      (key)
    );

    wrl_capture_ctl #(.KEY_W(KEY_W)) ctl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (host_rd),
        .key     (key),
        .is_dw0  (is_dw0),
        .capture (capture)
    );

    wrl_snapshot snap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (host_rd),
        .capture   (capture),
        .region    (region),
        .dw_sel    (dw_sel),
        .csr_word  (csr_word),
        .sram_word (sram_word),
        .rdata     (host_rdata),
        .rvalid    (host_rvalid)
    );

    // Route the capture strobe to the region being read.
    assign snap_csr  = capture && (region == REGION_CSR);
    assign snap_sram = capture && (region == REGION_SRAM);
endmodule

// File: rtl/wide_rd_latch_chk.sv
// Module: wide_rd_latch_chk
// Property checker for wide_rd_latch. It keeps its own record of the last
// word read and judges the strobes and the response timing against it.
module wide_rd_latch_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_rvalid,
    input logic              snap_csr,
    input logic              snap_sram
);
    logic              sram_sel;
    logic [1:0]        dw_now;
    logic [ADDR_W-4:0] key_now;
    logic [ADDR_W-4:0] last_key;
    logic              seen;

    // Independent decode of the request, for the checker's own use.
    assign sram_sel = host_addr[ADDR_W-1];
    assign dw_now   = sram_sel ? {1'b0, host_addr[2]} : host_addr[3:2];
    assign key_now  = {host_addr[ADDR_W-1:4], sram_sel & host_addr[3]};

    // Remember the word of the last read since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            last_key <= '0;
        end else if (host_rd) begin
            seen     <= 1'b1;
            last_key <= key_now;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !host_rvalid);
    // R8
    rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);
    // R8
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid);
    // R5
    snap_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_csr || snap_sram) |-> host_rd);
    // R5
    snap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({snap_csr, snap_sram}));
    // R2
    csr_dw0_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !sram_sel && dw_now == 2'd0) |-> snap_csr);
    // R7
    sram_dw0_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && sram_sel && dw_now == 2'd0) |-> snap_sram);
    // R4
    repeat_no_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && seen && key_now == last_key && dw_now != 2'd0)
        |-> !(snap_csr || snap_sram));
    // R3
    new_word_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && seen && key_now != last_key) |-> (snap_csr || snap_sram));
    // R6
    first_read_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !seen) |-> (snap_csr || snap_sram));
endmodule

bind wide_rd_latch wide_rd_latch_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_rvalid (host_rvalid),
    .snap_csr    (snap_csr),
    .snap_sram   (snap_sram)
);

// File: tb/wide_rd_latch_tb_top.sv
// Bench for wide_rd_latch.
// A behavioural bank whose live words drift, plus a reference model that
// is stepped and compared at every falling edge.
module wide_rd_latch_tb_top;
    localparam int ADDR_W = 14;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               host_rd = 1'b0;
    logic [ADDR_W-1:0]  host_addr = '0;
    logic [31:0]        host_rdata;
    logic               host_rvalid;
    logic [ADDR_W-6:0]  csr_idx;
    logic [127:0]       csr_word;
    logic [ADDR_W-5:0]  sram_idx;
    logic [63:0]        sram_word;
    logic               snap_csr;
    logic               snap_sram;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [31:0] drift = 32'h1000_0000;
    int csr_gen  [8];
    int sram_gen [8];

    always #4 clk = ~clk;

    wide_rd_latch #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_addr(host_addr),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .csr_idx(csr_idx), .csr_word(csr_word),
        .sram_idx(sram_idx), .sram_word(sram_word),
        .snap_csr(snap_csr), .snap_sram(snap_sram)
    );

    function automatic logic [127:0] mk_csr(logic [31:0] idx, logic [31:0] g, logic [31:0] d);
        return {8'hC0, idx[7:0], g[15:0], d, ~d, 16'hA5A5, g[7:0] ^ idx[7:0], 8'h3C};
    endfunction

    function automatic logic [63:0] mk_sram(logic [31:0] idx, logic [31:0] g, logic [31:0] d);
        return {8'h5E, idx[7:0], g[15:0], d ^ 32'h0F0F_0F0F};
    endfunction

    // Live bank words, changing with drift and with every clear-on-read event.
    always_comb begin
        csr_word  = mk_csr(32'(csr_idx), csr_gen[csr_idx[2:0]], drift);
        sram_word = mk_sram(32'(sram_idx), sram_gen[sram_idx[2:0]], drift);
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            csr_gen[i]  = 0;
            sram_gen[i] = 0;
        end
    end

    always @(posedge clk) begin
        if (snap_csr)  csr_gen[csr_idx[2:0]]   <= csr_gen[csr_idx[2:0]] + 1;
        if (snap_sram) sram_gen[sram_idx[2:0]] <= sram_gen[sram_idx[2:0]] + 1;
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model state.
    bit           m_valid = 1'b0;
    int           m_key   = 0;
    logic [127:0] m_latch = '0;
    int           m_cgen [8];
    int           m_sgen [8];
    bit           exp_pend = 1'b0;
    logic [31:0]  exp_data = '0;
    string        exp_req  = "R8";

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_cgen[i] = 0;
            m_sgen[i] = 0;
        end
    end

    // Step the model and compare, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                check(!host_rvalid && !snap_csr && !snap_sram, "R1",
                      {host_rvalid, snap_csr, snap_sram}, 0);
                m_valid  = 1'b0;
                exp_pend = 1'b0;
            end else begin
                check(host_rvalid == exp_pend, "R8", host_rvalid, exp_pend);
                if (exp_pend)
                    check(host_rdata == exp_data, exp_req, host_rdata, exp_data);
                if (host_rd) begin
                    bit           is_sram;
                    int           idx;
                    int           dw;
                    int           key;
                    bit           cap;
                    logic [127:0] fresh;
                    is_sram = host_addr[ADDR_W-1];
                    idx = is_sram ? int'(host_addr[ADDR_W-2:3]) : int'(host_addr[ADDR_W-2:4]);
                    dw  = is_sram ? int'(host_addr[2]) : int'(host_addr[3:2]);
                    key = is_sram ? (1 << 20) + idx : idx;
                    cap = !m_valid || dw == 0 || key != m_key;
                    if (!m_valid)          exp_req = "R6";
                    else if (is_sram)      exp_req = "R7";
                    else if (dw == 0)      exp_req = "R2";
                    else if (key != m_key) exp_req = "R3";
                    else                   exp_req = "R4";
                    if (is_sram) begin
                        check(int'(sram_idx) == idx, "R9", sram_idx, idx);
                        fresh = {64'b0, mk_sram(idx, m_sgen[idx % 8], drift)};
                    end else begin
                        check(int'(csr_idx) == idx, "R9", csr_idx, idx);
                        fresh = mk_csr(idx, m_cgen[idx % 8], drift);
                    end
                    check(snap_csr == (cap && !is_sram) && snap_sram == (cap && is_sram),
                          "R5", {snap_csr, snap_sram}, {cap && !is_sram, cap && is_sram});
                    if (cap) begin
                        m_latch = fresh;
                        m_valid = 1'b1;
                        m_key   = key;
                        if (is_sram) m_sgen[idx % 8]++;
                        else         m_cgen[idx % 8]++;
                    end
                    exp_data = m_latch[dw*32 +: 32];
                end else begin
                    check(!snap_csr && !snap_sram, "R5", {snap_csr, snap_sram}, 0);
                end
                exp_pend = host_rd;
            end
        end
    end

    function automatic logic [ADDR_W-1:0] ca(int idx, int dw);
        return {1'b0, 9'(idx), 2'(dw), 2'b00};
    endfunction

    function automatic logic [ADDR_W-1:0] sa(int idx, int dw);
        return {1'b1, 10'(idx), 1'(dw), 2'b00};
    endfunction

    task automatic rd(input logic [ADDR_W-1:0] a);
        @(posedge clk); #2;
        host_rd   = 1'b1;
        host_addr = a;
        drift     = drift + 32'h0001_0003;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            host_rd = 1'b0;
            drift   = drift + 32'h0000_0101;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        // R6: first read after reset, at an upper dword.
        rd(ca(1, 2));
        // R4: upper dwords of the tagged word, with live drift.
        rd(ca(1, 3));
        idle(2);
        rd(ca(1, 1));
        // R2: dword 0 recaptures, then a full sweep.
        rd(ca(1, 0)); rd(ca(1, 1)); rd(ca(1, 2)); rd(ca(1, 3));
        // R3: interleaved words force new captures.
        rd(ca(2, 1)); rd(ca(1, 2)); rd(ca(1, 3));
        // R7: SRAM pair, then cross-region interleave.
        rd(sa(3, 0)); rd(sa(3, 1)); rd(ca(3, 1)); rd(sa(3, 1));
        rd(sa(6, 1)); rd(ca(3, 0)); rd(sa(6, 1));
        // R9: byte lane bits ignored.
        rd(ca(4, 0)); rd(ca(4, 1) | 14'h3); rd(ca(4, 3) | 14'h1);
        idle(3);
        // R1/R6: reset mid-run empties the latch.
        @(posedge clk); #2 rst_n = 1'b0; host_rd = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        rd(ca(4, 2));
        rd(ca(4, 3));
        // Mixed traffic over a small set of words.
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r < 2) idle(1);
            else if (r < 7) rd(ca(int'($urandom_range(0, 3)), int'($urandom_range(0, 3))));
            else rd(sa(int'($urandom_range(0, 3)), int'($urandom_range(0, 1))));
        end
        idle(3);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule